// File: doc/BRIEF.md
# Strobe-Sampled CAM Host Front End

This block sits between the asynchronous host pins of a content-addressable memory and its synchronous core. The host frames each access with an active-low enable strobe. The block carries the strobe into the system clock domain through a two-flop synchroniser, and the falling edge it finds there marks the moment the host pins are sampled. At that moment the block latches the direction pin, the two chip selects, the address-valid pin and the field pins. On cycles where data flows in, it also latches the data bus and the validity pin. It then hands the core a one-clock command pulse that carries a decoded cycle kind, a field value and the captured data.

The meaning of the address-valid pin depends on a control-mode bit, which is loaded while reset is held. In hardware mode the pin tells a memory address apart from a control word on the field pins. In software mode it tells plain data apart from an instruction, and the instruction is carried on the low bits of the data bus. For a selected read, the block drives the core's read data and the entry's validity onto the bus outputs, but only while the strobe stays low. The tristate pins appear as separate in, out and output-enable signals.

Top module: `camHostFront`

## Requirements
- R1: While rstN is low, cmdValid, dqOe and vbOe are 0 and cmdData, cmdField and cmdEntryValid clear to 0. The control mode is loaded from modeSelSw during reset: 0 selects hardware mode and 1 selects software mode. modeSelSw has no effect once reset is released.
- R2: Whenever enN is high, dqOe and vbOe are 0. They drop as soon as enN rises, with no clock edge needed.
- R3: Each falling edge of enN that forms a selected, decodable cycle gives exactly one cmdValid pulse lasting one clock. The pulse is high after the third rising clock edge, counting from the first edge that samples enN low. The host holds all pins stable while enN is low.
- R4: A cycle counts as selected when cs1N or cs2N is low. With both chip selects high there is no pulse, no bus drive, and no change to cmdData or cmdEntryValid.
- R5: The cycle kinds are coded READ=0, WRITE=1, COMPARE=2 and CONTROL=3. In hardware mode, avN low with wN low gives WRITE and avN low with wN high gives READ. avN high with wN low gives COMPARE, and avN high with wN high gives CONTROL.
- R6: In software mode, avN low gives WRITE when wN is low and READ when wN is high. avN high with wN low gives CONTROL. avN high with wN high is ignored: there is no pulse and no bus drive.
- R7: cmdField takes acField, except for a software-mode CONTROL cycle, where it takes dqIn[FIELD_W-1:0].
- R8: Only cycles with wN low capture data. On such a cycle cmdData takes dqIn, and cmdEntryValid becomes 1 when vbIn is low (entry valid) and 0 when vbIn is high (entry empty). Every other cycle leaves both unchanged.
- R9: The bus is driven only after a READ cycle has been issued and while enN is still low. dqOe and vbOe go high together with the pulse. During that time dqOut equals rdData and vbOut equals the inverse of rdEntryValid, so low means valid. No other cycle kind drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSelSw | input | 1 | Control mode sampled during reset (1 = software mode) |
| enN | input | 1 | Active-low host enable strobe |
| wN | input | 1 | Direction pin: low = data into the block |
| cs1N | input | 1 | Active-low chip select, first |
| cs2N | input | 1 | Active-low chip select, second |
| avN | input | 1 | Address-valid pin, meaning set by the mode |
| acField | input | FIELD_W | Address/control field pins |
| dqIn | input | DATA_W | Data bus, input side |
| dqOut | output | DATA_W | Data bus, output side |
| dqOe | output | 1 | Data bus output enable |
| vbIn | input | 1 | Validity pin, input side (low = valid) |
| vbOut | output | 1 | Validity pin, output side (low = valid) |
| vbOe | output | 1 | Validity pin output enable |
| rdData | input | DATA_W | Read data from the core |
| rdEntryValid | input | 1 | Validity of the read entry from the core |
| cmdValid | output | 1 | One-clock command pulse |
| cmdKind | output | 2 | Decoded cycle kind |
| cmdField | output | FIELD_W | Captured address, control word or instruction |
| cmdData | output | DATA_W | Captured write data |
| cmdEntryValid | output | 1 | Captured validity (1 = valid) |

## Verification
The bench builds the block with an 8-bit data bus and a 4-bit field. At that size every combination of mode, both chip selects, direction and address-valid can be swept, which covers all 32 decode cases. Each case uses data, field and read values worked out arithmetically, so field sourcing, holding of data across non-write cycles and the read drive window are all checked against a model in the bench. Extra cycles with all-ones and all-zero buses test the edges of the field slice and of the validity polarity.

// File: rtl/camHostPkg.sv
package camHostPkg;

  typedef enum logic [1:0] {
    KIND_READ    = 2'd0,
    KIND_WRITE   = 2'd1,
    KIND_COMPARE = 2'd2,
    KIND_CONTROL = 2'd3
  } cmdKind_e;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic capture;       // latch the field
    logic loadData;      // latch data bus and validity
    logic fieldFromBus;  // field comes from the low data bits
    logic openRead;      // start the read drive window
    logic closeRead;     // strobe seen high: end the window
  } pathStrobes_t;

endpackage

// File: rtl/camHostCtrl.sv
module camHostCtrl
  import camHostPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSelSw,
  input  logic         enN,
  input  logic         wN,
  input  logic         cs1N,
  input  logic         cs2N,
  input  logic         avN,
  output pathStrobes_t strobes,
  output logic         cmdValid,
  output cmdKind_e     cmdKind
);

  localparam int SYNC_DEPTH = 3;

  logic [SYNC_DEPTH-1:0] enSync;
  logic                  swMode;
  logic                  fallSeen;
  logic                  selected;
  logic                  decOk;
  logic                  busField;
  logic                  issue;
  cmdKind_e              decKind;

  // Two flops to synchronise, one more to find the edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enSync <= '1;
      swMode <= modeSelSw;
    end else begin
      enSync <= {enSync[SYNC_DEPTH-2:0], enN};
    end
  end

  assign fallSeen = enSync[2] & ~enSync[1];
  assign selected = ~cs1N | ~cs2N;

  always_comb begin
    decKind  = KIND_READ;
    decOk    = 1'b1;
    busField = 1'b0;
    if (!swMode) begin
      if (!avN) decKind = wN ? KIND_READ : KIND_WRITE;
      else      decKind = wN ? KIND_CONTROL : KIND_COMPARE;
    end else begin
      if (!avN) begin
        decKind = wN ? KIND_READ : KIND_WRITE;
      end else if (!wN) begin
        decKind  = KIND_CONTROL;
        busField = 1'b1;
      end else begin
        decOk = 1'b0;
      end
    end
  end

  assign issue = fallSeen & selected & decOk;

  always_comb begin
    strobes.capture      = issue;
    strobes.loadData     = issue & ~wN;
    strobes.fieldFromBus = busField;
    strobes.openRead     = issue & (decKind == KIND_READ);
    strobes.closeRead    = enSync[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= KIND_READ;
    end else begin
      cmdValid <= issue;
      if (issue) cmdKind <= decKind;
    end
  end

endmodule

// File: rtl/camHostPath.sv
module camHostPath
  import camHostPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathStrobes_t       strobes,
  input  logic               enN,
  input  logic [FIELD_W-1:0] acField,
  input  logic [DATA_W-1:0]  dqIn,
  input  logic               vbIn,
  input  logic [DATA_W-1:0]  rdData,
  input  logic               rdEntryValid,
  output logic [DATA_W-1:0]  dqOut,
  output logic               dqOe,
  output logic               vbOut,
  output logic               vbOe,
  output logic [FIELD_W-1:0] cmdField,
  output logic [DATA_W-1:0]  cmdData,
  output logic               cmdEntryValid
);

  logic               readWin;
  logic [FIELD_W-1:0] busField;

  // The instruction field is cut from the data bus; a narrow bus is zero-extended.
  generate
    if (DATA_W >= FIELD_W) begin : g_sliceField
      assign busField = dqIn[FIELD_W-1:0];
    end else begin : g_padField
      assign busField = {{(FIELD_W-DATA_W){1'b0}}, dqIn};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdField      <= '0;
      cmdData       <= '0;
      cmdEntryValid <= 1'b0;
      readWin       <= 1'b0;
    end else begin
      if (strobes.capture)
        cmdField <= strobes.fieldFromBus ? busField : acField;
      if (strobes.loadData) begin
        cmdData       <= dqIn;
        cmdEntryValid <= ~vbIn;
      end
      if (strobes.openRead)       readWin <= 1'b1;
      else if (strobes.closeRead) readWin <= 1'b0;
    end
  end

  // The raw strobe gates the drivers, so they release at once.
  assign dqOe  = readWin & ~enN;
  assign vbOe  = dqOe;
  assign dqOut = dqOe ? rdData : '0;
  assign vbOut = dqOe ? ~rdEntryValid : 1'b1;

endmodule

// File: rtl/camHostFront.sv
module camHostFront
  import camHostPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSelSw,
  input  logic               enN,
  input  logic               wN,
  input  logic               cs1N,
  input  logic               cs2N,
  input  logic               avN,
  input  logic [FIELD_W-1:0] acField,
  input  logic [DATA_W-1:0]  dqIn,
  output logic [DATA_W-1:0]  dqOut,
  output logic               dqOe,
  input  logic               vbIn,
  output logic               vbOut,
  output logic               vbOe,
  input  logic [DATA_W-1:0]  rdData,
  input  logic               rdEntryValid,
  output logic               cmdValid,
  output logic [1:0]         cmdKind,
  output logic [FIELD_W-1:0] cmdField,
  output logic [DATA_W-1:0]  cmdData,
  output logic               cmdEntryValid
);

  pathStrobes_t strobes;
  cmdKind_e     kindReg;

  camHostCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSelSw(modeSelSw),
    .enN      (enN),
    .wN       (wN),
    .cs1N     (cs1N),
    .cs2N     (cs2N),
    .avN      (avN),
    .strobes  (strobes),
    .cmdValid (cmdValid),
    .cmdKind  (kindReg)
  );

  camHostPath #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .enN          (enN),
    .acField      (acField),
    .dqIn         (dqIn),
    .vbIn         (vbIn),
    .rdData       (rdData),
    .rdEntryValid (rdEntryValid),
    .dqOut        (dqOut),
    .dqOe         (dqOe),
    .vbOut        (vbOut),
    .vbOe         (vbOe),
    .cmdField     (cmdField),
    .cmdData      (cmdData),
    .cmdEntryValid(cmdEntryValid)
  );

  assign cmdKind = kindReg;

endmodule

// File: rtl/camHostChecks.sv
module camHostChecks (
  input logic       clk,
  input logic       rstN,
  input logic       enN,
  input logic       dqOe,
  input logic       vbOe,
  input logic       cmdValid,
  input logic [1:0] cmdKind
);

  assert_strobe_high_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    enN |-> (!dqOe && !vbOe));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_no_drive_nonread_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind != 2'd0) |-> !dqOe);

  assert_drive_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> (cmdKind == 2'd0));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!cmdValid && !dqOe));

endmodule

bind camHostFront camHostChecks i_checks (
  .clk     (clk),
  .rstN    (rstN),
  .enN     (enN),
  .dqOe    (dqOe),
  .vbOe    (vbOe),
  .cmdValid(cmdValid),
  .cmdKind (cmdKind)
);

// File: tb/test_camHostFront.sv
`timescale 1ns/1ps
module test_camHostFront;

  localparam int DW = 8;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN, modeSelSw, enN, wN, cs1N, cs2N, avN, vbIn, rdEntryValid;
  logic [FW-1:0] acField, cmdField;
  logic [DW-1:0] dqIn, dqOut, rdData, cmdData;
  logic          dqOe, vbOut, vbOe, cmdValid, cmdEntryValid;
  logic [1:0]    cmdKind;

  int checks = 0;
  int fails  = 0;
  int tick   = 0;
  int pulses = 0;
  int pulseTick = 0;
  int driveTick = 0;
  bit done = 1'b0;
  logic [1:0]    gotKind;
  logic [FW-1:0] gotField;
  logic [DW-1:0] modelData;
  logic          modelValid;

  always #2.5 clk = ~clk;

  camHostFront #(.DATA_W(DW), .FIELD_W(FW)) i_camHostFront (
    .clk(clk), .rstN(rstN), .modeSelSw(modeSelSw), .enN(enN), .wN(wN),
    .cs1N(cs1N), .cs2N(cs2N), .avN(avN), .acField(acField), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .vbIn(vbIn), .vbOut(vbOut), .vbOe(vbOe),
    .rdData(rdData), .rdEntryValid(rdEntryValid), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdField(cmdField), .cmdData(cmdData),
    .cmdEntryValid(cmdEntryValid)
  );

  always @(negedge clk) begin
    tick = tick + 1;
    if (cmdValid) begin
      pulses    = pulses + 1;
      pulseTick = tick;
      gotKind   = cmdKind;
      gotField  = cmdField;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input bit sw);
    rstN = 1'b0; modeSelSw = sw; enN = 1'b1; wN = 1'b1; cs1N = 1'b1; cs2N = 1'b1;
    avN = 1'b0; acField = '0; dqIn = '0; vbIn = 1'b1; rdData = '0; rdEntryValid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cmdValid in reset", int'(cmdValid), 0);
    chk("R1", "dqOe in reset", int'(dqOe), 0);
    chk("R1", "vbOe in reset", int'(vbOe), 0);
    chk("R1", "cmdData in reset", int'(cmdData), 0);
    chk("R1", "cmdEntryValid in reset", int'(cmdEntryValid), 0);
    rstN = 1'b1;
    modelData = '0; modelValid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    modeSelSw = ~sw;  // must have no effect after reset (R1)
  endtask

  task automatic runCycle(input bit sw, input bit c1, input bit c2, input bit we, input bit av,
                          input logic [FW-1:0] ac, input logic [DW-1:0] dq, input bit vb,
                          input logic [DW-1:0] rd, input bit rdv);
    bit            sel, ok, issue;
    int            kind;
    logic [FW-1:0] fieldExp;
    string         kreq;
    sel = !c1 || !c2;
    ok = 1'b1; kind = 0; fieldExp = ac;
    kreq = sw ? "R6" : "R5";
    if (!sw) begin
      if (!av) kind = we ? 0 : 1;
      else     kind = we ? 3 : 2;
    end else begin
      if (!av)       kind = we ? 0 : 1;
      else if (!we)  begin kind = 3; fieldExp = dq[FW-1:0]; end
      else           ok = 1'b0;
    end
    issue = sel && ok;

    @(negedge clk);
    #1;
    pulses = 0;
    cs1N = c1; cs2N = c2; wN = we; avN = av; acField = ac; dqIn = dq; vbIn = vb;
    rdData = rd; rdEntryValid = rdv;
    enN = 1'b0;
    driveTick = tick;
    repeat (4) @(negedge clk);
    #1;
    chk(issue ? "R3" : (sel ? "R6" : "R4"), "pulse count", pulses, issue ? 1 : 0);
    if (issue) begin
      chk("R3", "pulse latency", pulseTick - driveTick, 3);
      chk(kreq, "kind", int'(gotKind), kind);
      chk("R7", "field", int'(gotField), int'(fieldExp));
      if (!we) begin
        modelData  = dq;
        modelValid = !vb;
      end
    end
    chk("R8", "cmdData", int'(cmdData), int'(modelData));
    chk("R8", "cmdEntryValid", int'(cmdEntryValid), int'(modelValid));
    chk("R9", "dqOe in window", int'(dqOe), (issue && kind == 0) ? 1 : 0);
    chk("R9", "vbOe in window", int'(vbOe), (issue && kind == 0) ? 1 : 0);
    if (issue && kind == 0) begin
      chk("R9", "dqOut", int'(dqOut), int'(rd));
      chk("R9", "vbOut", int'(vbOut), int'(!rdv));
    end
    enN = 1'b1;
    #1;
    chk("R2", "dqOe after strobe rise", int'(dqOe), 0);
    chk("R2", "vbOe after strobe rise", int'(vbOe), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int sw = 0; sw < 2; sw++) begin
      doReset(sw[0]);
      for (int c = 0; c < 16; c++) begin
        logic [3:0] cb;
        cb = c[3:0];
        runCycle(sw[0], cb[0], cb[1], cb[2], cb[3],
                 FW'((c * 5 + sw * 3) & 15), DW'(c * 37 + sw * 91 + 1),
                 cb[0] ^ cb[2] ^ sw[0], DW'(~(c * 37 + sw * 91 + 1) ^ c),
                 cb[1] ^ sw[0]);
      end
      // Boundary patterns: all ones then all zeros on the buses.
      runCycle(sw[0], 1'b0, 1'b0, 1'b0, 1'b1, '1, '1, 1'b1, '1, 1'b1);
      runCycle(sw[0], 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
      runCycle(sw[0], 1'b0, 1'b1, 1'b1, 1'b0, '1, '1, 1'b0, '1, 1'b1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule